// File: doc/BRIEF.md
# Arbitrated Crossbar Router

This block moves one word per cycle from each of N source ports to any of N destination ports through a full N x N crossbar. Each source has its own request valid, a destination index, a data word and a ready return. Sources that aim at different destinations all go through in the same cycle. When several sources name the same destination, one of them is chosen per cycle. The others are refused and keep their request up until they are served. In this way any traffic pattern, including every port hitting one destination, drains in a bounded number of cycles.

Each destination has its own round-robin arbiter with a rotating priority pointer. A source's ready is combinational in the cycle it is granted. The delivered word appears on that destination's output one clock later. A two-state machine raises a busy flag after any cycle in which a valid request was refused. Its states are `ST_IDLE` and `ST_BACKLOG`. It takes transition LOSE (`ST_IDLE` to `ST_BACKLOG`) when a refusal occurs and transition CLEAR (`ST_BACKLOG` to `ST_IDLE`) after a cycle with no refusal. It stays in its state otherwise.

Top module: `xbar_router`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data` and `busy` are all zero, and every arbiter pointer returns to index 0.
- R2: Valid requests that all name distinct destinations are all granted (`req_ready` high) in the same cycle they are presented.
- R3: A source granted in cycle t has its data on slice `out_data[d*DATA_W +: DATA_W]` of its destination d, with `out_valid[d]` high, in cycle t+1.
- R4: Per destination at most one source is granted per cycle, and `req_ready` is never high for a source whose `req_valid` is low.
- R5: Each destination's pointer starts at 0. The winner is the first requesting source at an index at or above the pointer, wrapping from N-1 to 0. After a grant the pointer moves to winner+1, wrapping to 0.
- R6: Refused sources get no ready and keep requesting. K sources contending for one destination drain in exactly K cycles, so a pattern drains in as many cycles as its largest per-destination contention.
- R7: `out_valid[d]` is low in cycle t+1 when no source was granted to destination d in cycle t.
- R8: `busy` is high in cycle t+1 exactly when, in cycle t, at least one source had `req_valid` high and `req_ready` low.
- R9: A source may name its own index as destination and is served like any other.
- R10: A source with `req_valid` low has no effect: its destination and data fields change neither grants nor outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Per-source request valid |
| req_dest | input | N*IDX_W | Per-source destination index, source s at bits s*IDX_W |
| req_data | input | N*DATA_W | Per-source data word, source s at bits s*DATA_W |
| req_ready | output | N | Per-source grant, combinational |
| out_valid | output | N | Per-destination delivery strobe, registered |
| out_data | output | N*DATA_W | Per-destination delivered word, registered |
| busy | output | 1 | Backlog flag from the two-state machine |

## Verification
Full shifted permutations, including the identity where every port targets itself, test that conflict-free traffic finishes in one cycle and is not serialised. Hotspot patterns, where all ports target one destination, test the rotation order and the K-cycle drain. Repeating a hotspot on the same destination shows that the pointer carries over from one burst to the next. Two-to-one pairings and a sparse subset that sits among idle ports with live-looking fields separate per-destination independence from global stalling, and show that idle ports are ignored. The directed cases check the exact winner order around the wrap point.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_BACKLOG = 1'b1
    } backlog_state_e;
endpackage

// File: rtl/xbar_rr_arbiter.sv
module xbar_rr_arbiter #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win;

    // Scan from the pointer upward, wrapping, and take the first requester.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(ptr_q) + i;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                any        = 1'b1;
                win        = IW'(idx);
                grant[idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (any)
            ptr_q <= (int'(win) == N - 1) ? '0 : win + 1'b1;
    end

    // R4: a single winner, and only among requesters
    a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r4_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R5: a port just served loses the next cycle if anyone else asks
    for (genvar k = 0; k < N; k++) begin : g_rot
        a_r5_rotate: assert property (@(posedge clk) disable iff (!rst_n)
            grant[k] |=> (!grant[k] || $countones(req) <= 1));
    end
endmodule

// File: rtl/xbar_backlog_fsm.sv
module xbar_backlog_fsm
    import xbar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic refused,
    output logic busy
);
    backlog_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (refused)  state_d = ST_BACKLOG;  // LOSE
            ST_BACKLOG: if (!refused) state_d = ST_IDLE;     // CLEAR
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == ST_BACKLOG);
    end

    // R8: busy tracks refusals one cycle later
    a_r8_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> busy);
    a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !refused |=> !busy);
endmodule

// File: rtl/xbar_router.sv
module xbar_router #(
    parameter int N      = 32,
    parameter int DATA_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_valid,
    input  logic [N*IDX_W-1:0]  req_dest,
    input  logic [N*DATA_W-1:0] req_data,
    output logic [N-1:0]        req_ready,
    output logic [N-1:0]        out_valid,
    output logic [N*DATA_W-1:0] out_data,
    output logic                busy
);
    logic [N-1:0]        match [N];
    logic [N-1:0]        grant [N];
    logic [N-1:0]        gany;
    logic [DATA_W-1:0]   sel   [N];
    logic                refused;

    // Request matrix: row d holds the sources aiming at destination d.
    always_comb begin
        for (int d = 0; d < N; d++)
            for (int s = 0; s < N; s++)
                match[d][s] = req_valid[s] &&
                              (req_dest[s*IDX_W +: IDX_W] == IDX_W'(d));
    end

    for (genvar d = 0; d < N; d++) begin : g_dst
        xbar_rr_arbiter #(.N(N)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (match[d]),
            .grant (grant[d]),
            .any   (gany[d])
        );
    end

    // Each source wins at most one column, so OR-reduce the grant rows.
    always_comb begin
        req_ready = '0;
        for (int d = 0; d < N; d++)
            req_ready = req_ready | grant[d];
    end

    // One-hot AND-OR data selection per destination.
    always_comb begin
        for (int d = 0; d < N; d++) begin
            sel[d] = '0;
            for (int s = 0; s < N; s++)
                if (grant[d][s])
                    sel[d] = sel[d] | req_data[s*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
        end else begin
            for (int d = 0; d < N; d++) begin
                out_valid[d] <= gany[d];
                if (gany[d])
                    out_data[d*DATA_W +: DATA_W] <= sel[d];
            end
        end
    end

    assign refused = |(req_valid & ~req_ready);

    xbar_backlog_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .refused (refused),
        .busy    (busy)
    );

    // R4: no ready without a request
    a_r4_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    for (genvar s = 0; s < N; s++) begin : g_src_chk
        // R2: a source alone on its destination is served at once
        a_r2_lone_served: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[s] && $countones(match[req_dest[s*IDX_W +: IDX_W]]) == 1)
            |-> req_ready[s]);
    end

    for (genvar d = 0; d < N; d++) begin : g_dst_chk
        // R3: a delivery strobe needs a handshake on that column one cycle before
        a_r3_delivery_cause: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[d] |-> $past(|(match[d] & req_ready)));
    end
endmodule

// File: tb/test_xbar_router.sv
module test_xbar_router;
    localparam int N      = 32;
    localparam int DATA_W = 16;
    localparam int IW     = $clog2(N);

    typedef struct packed {
        logic [1:0] kind;   // 0 shift perm, 1 hotspot, 2 pairs, 3 sparse
        logic [7:0] arg;
        logic [7:0] cycles;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd0,  8'd1},   // identity, self targets (R9)
        '{2'd0, 8'd7,  8'd1},
        '{2'd0, 8'd31, 8'd1},
        '{2'd1, 8'd4,  8'd32},
        '{2'd1, 8'd4,  8'd32},  // pointer carries over
        '{2'd2, 8'd3,  8'd2},
        '{2'd3, 8'd17, 8'd8},   // idle ports carry live fields (R10)
        '{2'd1, 8'd31, 8'd32}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        req_valid = '0;
    logic [N*IW-1:0]     req_dest = '0;
    logic [N*DATA_W-1:0] req_data = '0;
    logic [N-1:0]        req_ready;
    logic [N-1:0]        out_valid;
    logic [N*DATA_W-1:0] out_data;
    logic                busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [N-1:0]        v;
    int                  dst  [N];
    logic [DATA_W-1:0]   dat  [N];
    int                  mptr [N];

    always #5 clk = ~clk;

    xbar_router #(.N(N), .DATA_W(DATA_W)) i_xbar_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_data(req_data), .req_ready(req_ready), .out_valid(out_valid),
        .out_data(out_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply();
        for (int s = 0; s < N; s++) begin
            req_valid[s]                 = v[s];
            req_dest[s*IW +: IW]         = IW'(dst[s]);
            req_data[s*DATA_W +: DATA_W] = dat[s];
        end
    endtask

    task automatic clear_all();
        v = '0;
        for (int s = 0; s < N; s++) begin
            dst[s] = 0;
            dat[s] = '0;
        end
    endtask

    // One clock: inputs applied after posedge, ready checked at negedge,
    // outputs checked just after the next posedge, then the model advances.
    task automatic cycle();
        logic [N-1:0]      eg;
        logic [N-1:0]      ov;
        logic [DATA_W-1:0] ed [N];
        int                ws [N];
        bit                pend;
        apply();
        @(negedge clk);
        eg = '0;
        ov = '0;
        for (int d = 0; d < N; d++) begin
            ed[d] = '0;
            ws[d] = 0;
            for (int i = 0; i < N; i++) begin
                int idx;
                idx = (mptr[d] + i) % N;
                if (!ov[d] && v[idx] && dst[idx] == d) begin
                    ov[d]   = 1'b1;
                    eg[idx] = 1'b1;
                    ed[d]   = dat[idx];
                    ws[d]   = idx;
                end
            end
        end
        chk(req_ready == eg, "R2/R4/R5 ready vector", 64'(req_ready), 64'(eg));
        pend = |(v & ~eg);
        @(posedge clk);
        #1;
        chk(out_valid == ov, "R3/R7 out_valid", 64'(out_valid), 64'(ov));
        for (int d = 0; d < N; d++)
            if (ov[d])
                chk(out_data[d*DATA_W +: DATA_W] == ed[d], "R3 out_data",
                    64'(out_data[d*DATA_W +: DATA_W]), 64'(ed[d]));
        chk(busy == pend, "R8 busy", 64'(busy), 64'(pend));
        for (int d = 0; d < N; d++)
            if (ov[d]) mptr[d] = (ws[d] + 1) % N;
        v = v & ~eg;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clear_all();
        apply();
        for (int d = 0; d < N; d++) mptr[d] = 0;
        repeat (2) @(posedge clk);
        #1;
        chk(out_valid == '0, "R1 out_valid in reset", 64'(out_valid), 64'h0);
        chk(out_data == '0, "R1 out_data in reset", 64'(out_data[63:0]), 64'h0);
        chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog actual=hung expected=drained");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Table walk
        for (int vi = 0; vi < 8; vi++) begin
            int n;
            clear_all();
            for (int s = 0; s < N; s++) begin
                dat[s] = DATA_W'((vi << 8) | s);
                unique case (VECS[vi].kind)
                    2'd0: begin v[s] = 1'b1; dst[s] = (s + int'(VECS[vi].arg)) % N; end
                    2'd1: begin v[s] = 1'b1; dst[s] = int'(VECS[vi].arg); end
                    2'd2: begin v[s] = 1'b1; dst[s] = (s / 2 + int'(VECS[vi].arg)) % N; end
                    default: begin v[s] = (s % 4 == 0); dst[s] = int'(VECS[vi].arg); end
                endcase
            end
            n = 0;
            while (|v && n < 2 * N) begin
                cycle();
                n++;
            end
            chk(n == int'(VECS[vi].cycles), "R6 drain cycles", 64'(n),
                64'(VECS[vi].cycles));
        end

        // R5 directed: fresh pointers, sources 5 and 20 to destination 9
        do_reset();
        clear_all();
        v[5] = 1'b1; dst[5] = 9; dat[5] = 16'h0505;
        v[20] = 1'b1; dst[20] = 9; dat[20] = 16'h2020;
        apply();
        #2;
        chk(req_ready == 32'h0000_0020, "R5 first winner from pointer 0",
            64'(req_ready), 64'h20);
        cycle();
        cycle();
        chk(out_data[9*DATA_W +: DATA_W] == 16'h2020, "R5 second winner",
            64'(out_data[9*DATA_W +: DATA_W]), 64'h2020);
        // Pointer now 21: source 25 beats source 20
        v[20] = 1'b1; v[25] = 1'b1; dst[25] = 9; dat[25] = 16'h2525;
        apply();
        #2;
        chk(req_ready == 32'h0200_0000, "R5 wrap order after pointer 21",
            64'(req_ready), 64'h200_0000);
        cycle();
        cycle();
        chk(busy == 1'b0, "R8 busy clears after drain", 64'(busy), 64'h0);

        // R10: idle source with live fields aimed at the same destination
        clear_all();
        v[7] = 1'b1; dst[7] = 5; dat[7] = 16'h7777;
        v[3] = 1'b0; dst[3] = 5; dat[3] = 16'hFFFF;
        apply();
        #2;
        chk(req_ready == 32'h80, "R10 idle source not granted",
            64'(req_ready), 64'h80);
        cycle();
        chk(out_data[5*DATA_W +: DATA_W] == 16'h7777, "R10 idle data ignored",
            64'(out_data[5*DATA_W +: DATA_W]), 64'h7777);

        // R10/R7: nobody valid, all fields busy-looking
        clear_all();
        for (int s = 0; s < N; s++) begin
            dst[s] = 2;
            dat[s] = 16'hDEAD;
        end
        cycle();
        chk(out_valid == '0, "R7 no strobes with no requests",
            64'(out_valid), 64'h0);

        // R9: single self-targeting source
        clear_all();
        v[31] = 1'b1; dst[31] = 31; dat[31] = 16'h3131;
        cycle();
        chk(out_valid == 32'h8000_0000, "R9 self target delivered",
            64'(out_valid), 64'h8000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule